// File: doc/BRIEF.md
# Register-Programmed PWM Generator

A single-channel pulse-width modulator configured through a small word-wide register bus. Software sets a period limit and a duty threshold. It then sets a run bit. While the channel runs, an up-counter steps once per clock from zero to the period limit and then restarts. The output is high while the counter is below the duty threshold. A polarity bit flips the final output.

The period and duty registers have no shadow copies. A new value takes effect at the next clock edge, even mid-period. Software must therefore order its writes so that no intermediate pairing produces a spurious pulse. The period register reads back, so software can compare the old period with the new one before it chooses that order. The polarity bit is locked while the channel runs.

Top module: `pwm_unit`

## Requirements
- R1: After reset, all four registers read 0, the counter is 0 and `pwm_out` is low.
- R2: Register decode uses `bus_addr[3:2]`: 0 selects the period limit (16 bits), 1 the duty threshold (16 bits), 2 the run bit (bit 0), 3 the polarity bit (bit 0). A write updates the register at the clock edge. Every register reads back on `bus_rdata`, and unused bits read 0.
- R3: While running, the counter advances by one per clock from 0 up to the period limit, then returns to 0, so one period lasts period limit + 1 clocks.
- R4: While running, `pwm_out` in a cycle equals (counter < duty threshold) of the previous cycle, XOR the polarity bit. The output is registered, with one clock of latency.
- R5: A duty threshold of 0 gives a constant inactive level. A duty threshold above the period limit gives a constant active level.
- R6: While the run bit is 0, the counter is held at 0 and `pwm_out` sits at the polarity bit (low for normal polarity, high for inverted).
- R7: A polarity write while the run bit is 1 is ignored, and register 3 keeps its old value.
- R8: With the polarity bit at 1, the active level is low and the inactive level is high.
- R9: If a live write lowers the period limit to or below the current count, the counter returns to 0 on the next clock.
- R10: Period and duty writes while running take effect at the next clock edge, with no buffering until the period ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the counter and the registers |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte address; bits [3:2] pick the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from the addressed register |
| pwm_out | output | 1 | Modulated output after polarity |

## Verification
Two things can land in the same clock edge: a live write to the period limit and the counter's own wrap or increment decision. The bench drives that collision by lowering the limit below a count it has tracked while the counter runs, and by writing the duty threshold on the edge where the counter crosses it. A clock-accurate model in the bench queues the expected output for every cycle, and a monitor compares that queue against `pwm_out`. A further collision is a polarity write issued while the run bit is set. That case is judged by reading register 3 back and by the output level that follows.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int PWM_W = 16;

  typedef enum logic [1:0] {
    SEL_LIMIT = 2'd0,
    SEL_DUTY  = 2'd1,
    SEL_RUN   = 2'd2,
    SEL_POL   = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic [PWM_W-1:0] limit;
    logic [PWM_W-1:0] duty;
    logic             run;
    logic             pol;
  } pwm_cfg_t;
endpackage

// File: rtl/pwm_regfile.sv
module pwm_regfile
  import pwm_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PWM_W-1:0]  bus_wdata,
  output logic [PWM_W-1:0]  bus_rdata,
  output pwm_cfg_t          cfg
);
  localparam int PAD_W = PWM_W - 1;

  reg_sel_e sel;
  logic     wr_en;
  pwm_cfg_t cfg_nxt;

  assign sel   = reg_sel_e'(bus_addr[3:2]);
  assign wr_en = bus_sel & bus_wr;

  always_comb begin
    cfg_nxt = cfg;
    unique case (sel)
      SEL_LIMIT: cfg_nxt.limit = bus_wdata;
      SEL_DUTY:  cfg_nxt.duty  = bus_wdata;
      SEL_RUN:   cfg_nxt.run   = bus_wdata[0];
      SEL_POL:   if (!cfg.run) cfg_nxt.pol = bus_wdata[0];
      default:   cfg_nxt = cfg;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cfg <= '0;
    else if (wr_en) cfg <= cfg_nxt;
  end

  always_comb begin
    unique case (sel)
      SEL_LIMIT: bus_rdata = cfg.limit;
      SEL_DUTY:  bus_rdata = cfg.duty;
      SEL_RUN:   bus_rdata = {{PAD_W{1'b0}}, cfg.run};
      SEL_POL:   bus_rdata = {{PAD_W{1'b0}}, cfg.pol};
      default:   bus_rdata = '0;
    endcase
  end

  // R7
  pol_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg.run |=> $stable(cfg.pol));

  // R2
  duty_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_DUTY) |=> cfg.duty == $past(bus_wdata));
endmodule

// File: rtl/pwm_counter.sv
module pwm_counter
  import pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [PWM_W-1:0] limit,
  output logic [PWM_W-1:0] cnt
);
  localparam logic [PWM_W-1:0] ONE = {{(PWM_W-1){1'b0}}, 1'b1};

  logic [PWM_W-1:0] cnt_nxt;
  logic             at_end;

  assign at_end = (cnt >= limit);

  always_comb begin
    if (!run)        cnt_nxt = '0;
    else if (at_end) cnt_nxt = '0;
    else             cnt_nxt = cnt + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt_nxt;
  end

  // R6
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> cnt == '0);

  // R3
  step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt < limit) |=> cnt == $past(cnt) + ONE);

  // R9
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt >= limit) |=> cnt == '0);
endmodule

// File: rtl/pwm_compare.sv
module pwm_compare
  import pwm_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             pol,
  input  logic [PWM_W-1:0] cnt,
  input  logic [PWM_W-1:0] duty,
  output logic             pwm_out
);
  logic active;
  logic out_nxt;

  assign active  = run & (cnt < duty);
  assign out_nxt = active ^ pol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pwm_out <= 1'b0;
    else        pwm_out <= out_nxt;
  end

  // R6
  idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> pwm_out == $past(pol));

  // R5
  zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (duty == '0) |=> pwm_out == $past(pol));
endmodule

// File: rtl/pwm_unit.sv
module pwm_unit
  import pwm_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PWM_W-1:0]  bus_wdata,
  output logic [PWM_W-1:0]  bus_rdata,
  output logic              pwm_out
);
  pwm_cfg_t         cfg;
  logic [PWM_W-1:0] cnt;

  pwm_regfile #(.ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cfg(cfg)
  );

  pwm_counter cnt_i (
    .clk(clk), .rst_n(rst_n), .run(cfg.run), .limit(cfg.limit), .cnt(cnt)
  );

  pwm_compare cmp_i (
    .clk(clk), .rst_n(rst_n), .run(cfg.run), .pol(cfg.pol), .cnt(cnt),
    .duty(cfg.duty), .pwm_out(pwm_out)
  );
endmodule

// File: tb/pwm_unit_tb_top.sv
module pwm_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        pwm_out;

  int checks = 0;
  int fails = 0;
  string tag = "R1";
  bit exp_q[$];
  bit done = 1'b0;

  // spec model state
  logic [15:0] m_limit, m_duty, m_cnt;
  logic        m_run, m_pol;

  always #2.5 clk = ~clk;

  pwm_unit dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_out(pwm_out)
  );

  // reference model: pushes the expected output for each clock
  always @(posedge clk) begin
    logic [15:0] n_cnt;
    logic        n_out;
    if (!rst_n) begin
      m_limit = '0; m_duty = '0; m_cnt = '0; m_run = 1'b0; m_pol = 1'b0;
    end else begin
      n_cnt = !m_run ? 16'd0 : (m_cnt >= m_limit ? 16'd0 : m_cnt + 16'd1);
      n_out = m_run ? ((m_cnt < m_duty) ^ m_pol) : m_pol;
      if (bus_sel && bus_wr) begin
        case (bus_addr[3:2])
          2'd0: m_limit = bus_wdata;
          2'd1: m_duty  = bus_wdata;
          2'd2: m_run   = bus_wdata[0];
          default: if (!m_run) m_pol = bus_wdata[0];
        endcase
      end
      m_cnt = n_cnt;
      exp_q.push_back(n_out);
    end
  end

  // monitor: pops and compares at the falling edge
  always @(negedge clk) begin
    bit e;
    if (rst_n && exp_q.size() > 0) begin
      e = exp_q.pop_front();
      checks++;
      if (pwm_out !== e) begin
        fails++;
        $display("FAIL %s pwm_out actual=%0b expected=%0b t=%0t", tag, pwm_out, e, $time);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [15:0] exp, input string t);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1;
    checks++;
    if (bus_rdata !== exp) begin
      fails++;
      $display("FAIL %s read addr=%0h actual=%0h expected=%0h", t, a, bus_rdata, exp);
    end
    bus_sel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (pwm_out !== 1'b0) begin
      fails++;
      $display("FAIL R1 pwm_out in reset actual=%0b expected=0", pwm_out);
    end
    rst_n = 1'b1;
    rd(4'h0, 16'h0, "R1"); rd(4'h4, 16'h0, "R1");
    rd(4'h8, 16'h0, "R1"); rd(4'hC, 16'h0, "R1");

    // R2: decode and readback
    tag = "R2";
    wr(4'h0, 16'd4); wr(4'h4, 16'd2);
    rd(4'h0, 16'd4, "R2"); rd(4'h4, 16'd2, "R2");
    wr(4'h8, 16'hFFFF);
    rd(4'h8, 16'h0001, "R2");

    // R3 / R4: running waveform, period 5, high for 2
    tag = "R3_R4";
    idle(23);

    // R5: duty 0 then duty above limit
    tag = "R5";
    wr(4'h4, 16'd0); idle(12);
    wr(4'h4, 16'd9); idle(12);

    // R7: polarity write while running is ignored
    tag = "R7";
    wr(4'hC, 16'd1);
    rd(4'hC, 16'd0, "R7");
    wr(4'h4, 16'd2); idle(6);

    // R6: stopped, then polarity accepted
    tag = "R6";
    wr(4'h8, 16'd0); idle(6);
    wr(4'hC, 16'd1);
    rd(4'hC, 16'd1, "R6");
    idle(5);

    // R8: inverted waveform
    tag = "R8";
    wr(4'h8, 16'd1); idle(15);
    wr(4'h8, 16'd0); wr(4'hC, 16'd0); idle(3);

    // R9: long period, then cut the limit below the running count
    tag = "R9";
    wr(4'h0, 16'd20); wr(4'h4, 16'd10); wr(4'h8, 16'd1);
    idle(14);
    wr(4'h0, 16'd3); idle(12);
    rd(4'h0, 16'd3, "R9");

    // R10: grow the period (limit then duty) and shrink it (duty then limit)
    tag = "R10";
    wr(4'h0, 16'd7); wr(4'h4, 16'd5); idle(17);
    wr(4'h4, 16'd1); wr(4'h0, 16'd2); idle(10);
    wr(4'h4, 16'd3); idle(4);
    wr(4'h4, 16'd0); idle(3);

    finish_run();
  end
endmodule